// File: doc/BRIEF.md
# Clock Digit Image Streamer

This block renders a packed time-of-day value as a raster image of glyph opacity values and streams it out on an AXI4-Stream master port. An on-chip font memory holds eleven glyphs (the ten decimal digits and a colon), each a grid of 4-bit opacity values loaded through a simple write port. A single start pulse captures the time word and the layout select, then the block emits exactly one frame whose lines are the selected glyph rows placed side by side.

Each time field is converted to a tens digit and a units digit before the first pixel is fetched. The frame is scanned row by row; within a row the characters go left to right, and within a character its columns go left to right. Every output byte is the 4-bit opacity of the font cell widened to 8 bits with the low nibble forced to all ones, ready for a downstream colour mixer. TUSER marks the first pixel of the frame and TLAST the last pixel of every row.

The control is a four-state machine. ST_IDLE waits for start and goes to ST_CONVERT when a start pulse arrives. ST_CONVERT registers the eleven glyph codes and always goes to ST_FETCH. ST_FETCH reads one font cell and always goes to ST_SEND. ST_SEND presents the pixel and stays there while TREADY is low; on a handshake it goes back to ST_FETCH, or to ST_IDLE if the pixel was the last of the frame.

Top module: `clkimg_streamer`

## Requirements
- R1: After reset, busy and m_tvalid are low.
- R2: Every output pixel equals {v, 4'hF}, where v is the 4-bit opacity stored in the font memory for that glyph, row and column.
- R3: With fmt_cs low the frame is 8 characters wide, in the order hour-tens, hour-units, colon, minute-tens, minute-units, colon, second-tens, second-units; a row holds 8*GLYPH_W pixels.
- R4: With fmt_cs high the frame is 11 characters wide: the 8-character layout followed by colon, centisecond-tens, centisecond-units; a row holds 11*GLYPH_W pixels.
- R5: time_in carries hours in [31:24], minutes in [23:16], seconds in [15:8] and centiseconds in [7:0]; each 8-bit field f shows tens digit (f/10)%10 and units digit f%10. Glyph code 0 to 9 is the digit and code 10 is the colon.
- R6: Pixels leave in row-major order: for each of the GLYPH_H glyph rows, every character in turn, every column of that character in turn.
- R7: m_tuser is high on the first pixel of the frame and low on every other pixel.
- R8: m_tlast is high on the last pixel of each row and on no other pixel; a frame holds GLYPH_H rows.
- R9: While m_tvalid is high and m_tready low, m_tvalid, m_tdata, m_tuser and m_tlast hold their values.
- R10: One accepted start pulse yields exactly one frame, built from time_in and fmt_cs as sampled on that pulse; later changes of those inputs do not affect it.
- R11: busy rises the cycle after an accepted start and falls the cycle after the final handshake; a start while busy is ignored and produces no further frame.
- R12: A font write with font_we high stores font_opa at (font_glyph, font_row, font_col); a write whose glyph is above 10, whose row is not below GLYPH_H or whose column is not below GLYPH_W changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame trigger pulse |
| fmt_cs | input | 1 | Layout select: 0 for 8 characters, 1 for 11 characters |
| time_in | input | 32 | Packed hours, minutes, seconds, centiseconds |
| font_we | input | 1 | Font write enable |
| font_glyph | input | 4 | Glyph code of the font write |
| font_row | input | $clog2(GLYPH_H) | Row of the font write |
| font_col | input | $clog2(GLYPH_W) | Column of the font write |
| font_opa | input | 4 | Opacity value written |
| busy | output | 1 | High while a frame is in progress |
| m_tvalid | output | 1 | Stream data valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 8 | Expanded opacity pixel |
| m_tuser | output | 1 | First pixel of frame |
| m_tlast | output | 1 | Last pixel of a row |

## Verification
The assertions assume that the sink never needs the stream to drop valid data and that the font is not rewritten while a frame is in flight; the bench only writes the font while busy is low. Row-length checks in the checker take the layout from fmt_cs sampled with an accepted start, so the stimulus changes fmt_cs and time_in freely after the trigger, which also exercises the capture. TREADY is drawn at random with several duty levels, from always ready to heavy back-pressure, so both the stall-hold and the back-to-back paths are covered.

// File: rtl/clkimg_pkg.sv
package clkimg_pkg;

    // glyph codes: 0..9 are digits, 10 is the separator
    localparam int GLYPH_NUM   = 11;
    localparam int LONG_CHARS  = 11;
    localparam int SHORT_CHARS = 8;
    localparam logic [3:0] COLON_CODE = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_FETCH,
        ST_SEND
    } scan_state_e;

    // position 0 is the leftmost character
    typedef logic [LONG_CHARS-1:0][3:0] glyph_line_t;

endpackage

// File: rtl/clkimg_glyph_map.sv
module clkimg_glyph_map
    import clkimg_pkg::*;
(
    input  logic [31:0] time_word,
    output glyph_line_t line
);

    // field 0 = hours (top byte) ... field 3 = centiseconds
    for (genvar f = 0; f < 4; f++) begin : g_field
        logic [7:0] fb;
        logic [7:0] tens8;
        logic [7:0] units8;

        assign fb     = time_word[31-8*f -: 8];
        assign tens8  = (fb / 8'd10) % 8'd10;
        assign units8 = fb % 8'd10;

        assign line[3*f]   = tens8[3:0];
        assign line[3*f+1] = units8[3:0];

        if (f < 3) begin : g_sep
            assign line[3*f+2] = COLON_CODE;
        end
    end

endmodule

// File: rtl/clkimg_font_ram.sv
module clkimg_font_ram #(
    parameter int DEPTH = 1056,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [3:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [3:0]    rd_data
);

    logic [3:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/clkimg_scan_fsm.sv
module clkimg_scan_fsm
    import clkimg_pkg::*;
#(
    parameter int GLYPH_H = 12,
    parameter int GLYPH_W = 8,
    localparam int ROW_W  = (GLYPH_H > 1) ? $clog2(GLYPH_H) : 1,
    localparam int COL_W  = (GLYPH_W > 1) ? $clog2(GLYPH_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fmt_long,
    input  logic             m_tready,
    output logic             accept,
    output logic             load_codes,
    output logic             rd_en,
    output logic [ROW_W-1:0] row,
    output logic [3:0]       char_idx,
    output logic [COL_W-1:0] col,
    output logic             busy,
    output logic             m_tvalid,
    output logic             m_tuser,
    output logic             m_tlast
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(GLYPH_H - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(GLYPH_W - 1);

    scan_state_e state_q, state_d;

    logic [3:0] char_last_idx;
    logic       col_end, char_end, row_end, frame_end, advance;

    assign char_last_idx = fmt_long ? 4'(LONG_CHARS - 1) : 4'(SHORT_CHARS - 1);
    assign col_end   = (col == COL_LAST);
    assign char_end  = (char_idx == char_last_idx);
    assign row_end   = (row == ROW_LAST);
    assign frame_end = col_end && char_end && row_end;
    assign advance   = (state_q == ST_SEND) && m_tready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CONVERT;
            ST_CONVERT: state_d = ST_FETCH;
            ST_FETCH:   state_d = ST_SEND;
            ST_SEND: begin
                if (m_tready) begin
                    state_d = frame_end ? ST_IDLE : ST_FETCH;
                end
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // raster counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row      <= '0;
            char_idx <= '0;
            col      <= '0;
        end else if (accept) begin
            row      <= '0;
            char_idx <= '0;
            col      <= '0;
        end else if (advance) begin
            if (col_end) begin
                col <= '0;
                if (char_end) begin
                    char_idx <= '0;
                    row      <= row_end ? '0 : row + 1'b1;
                end else begin
                    char_idx <= char_idx + 4'd1;
                end
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        accept     = 1'b0;
        load_codes = 1'b0;
        rd_en      = 1'b0;
        busy       = 1'b1;
        m_tvalid   = 1'b0;
        m_tuser    = 1'b0;
        m_tlast    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_CONVERT: load_codes = 1'b1;
            ST_FETCH:   rd_en = 1'b1;
            ST_SEND: begin
                m_tvalid = 1'b1;
                m_tuser  = (row == '0) && (char_idx == 4'd0) && (col == '0);
                m_tlast  = col_end && char_end;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkimg_streamer.sv
module clkimg_streamer
    import clkimg_pkg::*;
#(
    parameter int GLYPH_H = 12,
    parameter int GLYPH_W = 8,
    localparam int ROW_W  = (GLYPH_H > 1) ? $clog2(GLYPH_H) : 1,
    localparam int COL_W  = (GLYPH_W > 1) ? $clog2(GLYPH_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fmt_cs,
    input  logic [31:0]      time_in,
    input  logic             font_we,
    input  logic [3:0]       font_glyph,
    input  logic [ROW_W-1:0] font_row,
    input  logic [COL_W-1:0] font_col,
    input  logic [3:0]       font_opa,
    output logic             busy,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic [7:0]       m_tdata,
    output logic             m_tuser,
    output logic             m_tlast
);

    localparam int DEPTH = GLYPH_NUM * GLYPH_H * GLYPH_W;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             accept, load_codes, rd_en;
    logic [ROW_W-1:0] row;
    logic [3:0]       char_idx;
    logic [COL_W-1:0] col;
    logic [31:0]      time_q;
    logic             fmt_q;
    glyph_line_t      codes_d, codes_q;
    logic [3:0]       glyph_sel;
    logic             wr_ok;
    logic [AW-1:0]    wr_addr, rd_addr;
    logic [3:0]       opa;

    // trigger capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
            fmt_q  <= 1'b0;
        end else if (accept) begin
            time_q <= time_in;
            fmt_q  <= fmt_cs;
        end
    end

    clkimg_glyph_map u_map (
        .time_word (time_q),
        .line      (codes_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            codes_q <= '0;
        end else if (load_codes) begin
            codes_q <= codes_d;
        end
    end

    clkimg_scan_fsm #(
        .GLYPH_H (GLYPH_H),
        .GLYPH_W (GLYPH_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fmt_long   (fmt_q),
        .m_tready   (m_tready),
        .accept     (accept),
        .load_codes (load_codes),
        .rd_en      (rd_en),
        .row        (row),
        .char_idx   (char_idx),
        .col        (col),
        .busy       (busy),
        .m_tvalid   (m_tvalid),
        .m_tuser    (m_tuser),
        .m_tlast    (m_tlast)
    );

    // font addressing: ((glyph * H) + row) * W + col
    assign wr_ok = font_we
                && (int'(font_glyph) < GLYPH_NUM)
                && (int'(font_row) < GLYPH_H)
                && (int'(font_col) < GLYPH_W);

    assign wr_addr = (AW'(font_glyph) * AW'(GLYPH_H) + AW'(font_row)) * AW'(GLYPH_W)
                   + AW'(font_col);

    assign glyph_sel = codes_q[char_idx];
    assign rd_addr   = (AW'(glyph_sel) * AW'(GLYPH_H) + AW'(row)) * AW'(GLYPH_W)
                     + AW'(col);

    clkimg_font_ram #(
        .DEPTH (DEPTH)
    ) u_ram (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_addr (wr_addr),
        .wr_data (font_opa),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (opa)
    );

    assign m_tdata = {opa, 4'hF};

endmodule

// File: rtl/clkimg_streamer_chk.sv
module clkimg_streamer_chk #(
    parameter int GLYPH_H = 12,
    parameter int GLYPH_W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       fmt_cs,
    input logic       busy,
    input logic       m_tvalid,
    input logic       m_tready,
    input logic [7:0] m_tdata,
    input logic       m_tuser,
    input logic       m_tlast
);

    logic        fmt_f;
    logic [31:0] pix_cnt, col_cnt, row_cnt, row_len;

    assign row_len = fmt_f ? 32'(11 * GLYPH_W) : 32'(8 * GLYPH_W);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_f   <= 1'b0;
            pix_cnt <= '0;
            col_cnt <= '0;
            row_cnt <= '0;
        end else begin
            if (start && !busy) fmt_f <= fmt_cs;
            if (!busy) begin
                pix_cnt <= '0;
                col_cnt <= '0;
                row_cnt <= '0;
            end else if (m_tvalid && m_tready) begin
                pix_cnt <= pix_cnt + 1;
                col_cnt <= m_tlast ? '0 : col_cnt + 1;
                if (m_tlast) row_cnt <= row_cnt + 1;
            end
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata)
                                  && $stable(m_tuser) && $stable(m_tlast));

    // R2
    low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> m_tdata[3:0] == 4'hF);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_tvalid);

    // R7
    first_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tuser == (pix_cnt == 0)));

    // R8
    row_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tlast == (col_cnt == row_len - 1)));

    // R8
    row_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> row_cnt == 32'(GLYPH_H));

endmodule

bind clkimg_streamer clkimg_streamer_chk #(
    .GLYPH_H (GLYPH_H),
    .GLYPH_W (GLYPH_W)
) u_chk (.*);

// File: tb/tb_clkimg_streamer.sv
module tb_clkimg_streamer;

    localparam int CLK_PERIOD = 10;
    localparam int H = 12;
    localparam int W = 8;
    localparam int RW = $clog2(H);
    localparam int CW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst_n, start, fmt_cs, font_we, m_tready;
    logic [31:0]   time_in;
    logic [3:0]    font_glyph, font_opa;
    logic [RW-1:0] font_row;
    logic [CW-1:0] font_col;
    logic          busy, m_tvalid, m_tuser, m_tlast;
    logic [7:0]    m_tdata;

    logic [3:0] font_m [11][H][W];
    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkimg_streamer #(.GLYPH_H(H), .GLYPH_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_cs(fmt_cs), .time_in(time_in),
        .font_we(font_we), .font_glyph(font_glyph), .font_row(font_row),
        .font_col(font_col), .font_opa(font_opa), .busy(busy), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // glyph code at character position pos (R5 packing and split)
    function automatic logic [3:0] code_at(input logic [31:0] t, input int pos);
        int f = pos / 3;
        int k = pos % 3;
        int b = int'(t[31-8*f -: 8]);
        if (k == 2) return 4'd10;
        if (k == 0) return 4'((b / 10) % 10);
        return 4'(b % 10);
    endfunction

    task automatic write_px(input int g, input int r, input int c, input logic [3:0] v);
        font_glyph = 4'(g);
        font_row   = RW'(r);
        font_col   = CW'(c);
        font_opa   = v;
        font_we    = 1'b1;
        @(negedge clk);
        font_we    = 1'b0;
    endtask

    task automatic run_frame(input logic [31:0] t, input bit fm, input int ready_pct,
                             input bit poke, input string req);
        int n = fm ? 11 : 8;
        int npix = H * n * W;
        int k = 0, cyc = 0;
        int derr = 0, uerr = 0, lerr = 0, herr = 0;
        bit poked = 0;
        bit stalled = 0;
        logic [7:0] held = '0;
        int first_bad_act = 0, first_bad_exp = 0;
        @(negedge clk);
        time_in = t;
        fmt_cs  = fm;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        time_in = ~t;      // R10: later input changes must not matter
        fmt_cs  = ~fm;
        check(busy == 1'b1, "R11", "busy after start", busy, 1);
        while (k < npix && cyc < 20000) begin
            m_tready = (($urandom % 100) < ready_pct);
            start = 1'b0;
            if (poke && !poked && k == 5) begin
                start = 1'b1;  // R11: ignored trigger
                time_in = 32'h01020304;
                poked = 1;
            end
            if (stalled) begin
                if (!m_tvalid || m_tdata != held) herr++;
            end
            if (m_tvalid && m_tready) begin
                int r = k / (n * W);
                int rem = k % (n * W);
                int ch = rem / W;
                int c = rem % W;
                logic [7:0] exp_d = {font_m[code_at(t, ch)][r][c], 4'hF};
                if (m_tdata != exp_d) begin
                    if (derr == 0) begin
                        first_bad_act = m_tdata;
                        first_bad_exp = exp_d;
                    end
                    derr++;
                end
                if (m_tuser != (k == 0)) uerr++;
                if (m_tlast != (c == W - 1 && ch == n - 1)) lerr++;
                k++;
            end
            stalled = m_tvalid && !m_tready;
            held = m_tdata;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(k == npix, "R10", "pixel count of frame", k, npix);
        check(derr == 0, req, "pixel data (R2/R6)", first_bad_act, first_bad_exp);
        check(uerr == 0, "R7", "tuser errors", uerr, 0);
        check(lerr == 0, "R8", "tlast errors", lerr, 0);
        check(herr == 0, "R9", "stall hold errors", herr, 0);
        check(busy == 1'b0, "R11", "busy after final handshake", busy, 0);
        m_tready = 1'b1;
        begin
            int extra = 0;
            repeat (20) begin
                if (m_tvalid || busy) extra++;
                @(negedge clk);
            end
            check(extra == 0, "R11", "no extra frame after end", extra, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C10C));
        rst_n = 1'b0; start = 1'b0; fmt_cs = 1'b0; time_in = '0; font_we = 1'b0;
        font_glyph = '0; font_row = '0; font_col = '0; font_opa = '0; m_tready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(m_tvalid == 1'b0, "R1", "tvalid after reset", m_tvalid, 0);

        for (int g = 0; g < 11; g++)
            for (int r = 0; r < H; r++)
                for (int c = 0; c < W; c++) begin
                    logic [3:0] v = 4'($urandom);
                    font_m[g][r][c] = v;
                    write_px(g, r, c, v);
                end

        run_frame(32'h173B2A63, 1'b0, 100, 1'b0, "R3");
        run_frame(32'h173B2A63, 1'b1, 60, 1'b0, "R4");
        run_frame(32'h00000000, 1'b1, 30, 1'b1, "R4");
        run_frame(32'h00000000, 1'b0, 50, 1'b1, "R3");
        run_frame(32'hFFC8640A, 1'b1, 80, 1'b0, "R5");

        // R12: a legal rewrite takes effect, out-of-range writes do nothing
        font_m[1][0][0] = ~font_m[1][0][0];
        write_px(1, 0, 0, font_m[1][0][0]);
        write_px(0, H + 1, 0, ~font_m[1][1][0]);
        write_px(11, 0, 0, 4'hA);
        write_px(15, 0, 0, 4'h5);
        run_frame(32'h0B0B0B0B, 1'b1, 70, 1'b0, "R12");

        for (int i = 0; i < 7; i++) begin
            logic [31:0] t;
            t[31:24] = 8'($urandom % 24);
            t[23:16] = 8'($urandom % 60);
            t[15:8]  = 8'($urandom % 60);
            t[7:0]   = 8'($urandom % 100);
            run_frame(t, 1'($urandom), 20 + int'($urandom % 81), 1'b0, "R5");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule